// File: doc/BRIEF.md
# Registered Signed Adder-Subtractor

This block adds or subtracts two two's-complement words of `WIDTH` bits (8 by default). Both operands and an operation-select bit are taken into a single input register on every rising clock edge. The captured values drive a carry-propagate chain built from one-bit full-adder cells. A second register, on the output side, holds the wrapped result and a signed-overflow flag. A new operation can therefore enter on every cycle. The result of an operation presented before edge k is visible just after edge k+1.

Subtraction reuses the same chain. The captured second operand is bit-inverted and a 1 is fed into the least significant carry input. Addition feeds a 0 there. The overflow flag is the exclusive-or of the carry into the sign stage and the carry out of it. An active-low reset clears all registers at once, with no clock edge needed.

The block has no control state beyond its two register stages. It streams: one operation enters per cycle, and each one leaves two edges after it was presented.

Top module: `registered_addsub`

## Requirements
- R1: While `rst_n` is low, `sum_q` reads 0 and `ovf_q` reads 0. The first result after reset is released is the value for operands 0 and 0 in add mode, which is also 0 with no overflow.
- R2: With `sub_mode` = 0 (add), `sum_q` equals `(a_in + b_in) mod 2^WIDTH`.
- R3: With `sub_mode` = 1 (subtract), `sum_q` equals `(a_in - b_in) mod 2^WIDTH`.
- R4: In add mode, `ovf_q` is 1 exactly when the true signed sum lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. For the default width this includes 127 + 1 giving 0x80 with overflow, and -128 + -128 giving 0x00 with overflow.
- R5: In subtract mode, `ovf_q` is 1 exactly when the true signed difference lies outside the same range. For the default width this includes -128 - 1 giving 0x7F with overflow, and -128 - (-128) giving 0x00 without overflow.
- R6: Operands and mode presented before rising edge k show on `sum_q` and `ovf_q` after edge k+1. After edge k the outputs still show the previous operation.
- R7: The mode bit travels with its operands. When the mode and the operands change every cycle, each output reflects the mode that was presented together with its own operands.
- R8: Pulling `rst_n` low between clock edges clears `sum_q` and `ovf_q` at once, with no rising clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | WIDTH | First operand, two's complement |
| b_in | input | WIDTH | Second operand, two's complement |
| sub_mode | input | 1 | 0 = add, 1 = subtract (a_in - b_in) |
| sum_q | output | WIDTH | Registered wrapped result |
| ovf_q | output | 1 | Registered signed-overflow flag |

## Verification
Two things happen on the same edge. A fresh operand set and mode enter the input register, and the previous operation leaves the chain into the output register. The bench provokes this overlap by streaming every operand pair back to back, with the mode flipped on every cycle. In a second pass each pair gets the opposite mode. Each output is compared with a signed-integer result the bench computed two cycles earlier, so a mode that slipped by one stage, or a result taken from the wrong operands, shows up as a mismatch in either the sum or the flag.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    parameter int unsigned ADD_W = 8;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    logic half_x;

    always_comb begin
        half_x = x_i ^ y_i;
        s_o    = half_x ^ c_i;
        c_o    = (x_i & y_i) | (half_x & c_i);
    end

endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/ripple_addsub.sv
module ripple_addsub
    import addsub_pkg::*;
#(
    parameter int unsigned W = ADD_W
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  op_mode_e     mode_i,
    output logic [W-1:0] r_o,
    output logic         v_o
);

    logic [W-1:0] y_eff;
    logic [W:0]   carry;

    always_comb begin
        y_eff    = (mode_i == OP_SUB) ? ~y_i : y_i;
        carry[0] = (mode_i == OP_SUB);
    end

    for (genvar g = 0; g < W; g++) begin : g_stage
        fa_cell u_cell (
            .x_i (x_i[g]),
            .y_i (y_eff[g]),
            .c_i (carry[g]),
            .s_o (r_o[g]),
            .c_o (carry[g+1])
        );
    end

    // carry into the sign stage disagreeing with carry out of it
    assign v_o = carry[W] ^ carry[W-1];

endmodule

// File: rtl/registered_addsub.sv
module registered_addsub
    import addsub_pkg::*;
#(
    parameter int unsigned WIDTH = ADD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] sum_q,
    output logic             ovf_q
);

    localparam int unsigned IN_W  = 2 * WIDTH + 1;
    localparam int unsigned OUT_W = WIDTH + 1;

    logic [IN_W-1:0]  in_d, in_q;
    logic [OUT_W-1:0] out_d, out_q;
    logic [WIDTH-1:0] a_q, b_q, r_w;
    op_mode_e         mode_q;
    logic             v_w;

    assign in_d = {sub_mode, a_in, b_in};

    capture_reg #(.W(IN_W)) u_in_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (in_d),
        .q_o   (in_q)
    );

    assign mode_q = op_mode_e'(in_q[IN_W-1]);
    assign a_q    = in_q[2*WIDTH-1:WIDTH];
    assign b_q    = in_q[WIDTH-1:0];

    ripple_addsub #(.W(WIDTH)) u_chain (
        .x_i    (a_q),
        .y_i    (b_q),
        .mode_i (mode_q),
        .r_o    (r_w),
        .v_o    (v_w)
    );

    assign out_d = {v_w, r_w};

    capture_reg #(.W(OUT_W)) u_out_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (out_d),
        .q_o   (out_q)
    );

    assign sum_q = out_q[WIDTH-1:0];
    assign ovf_q = out_q[WIDTH];

    // behavioural references for the checks below
    logic [WIDTH-1:0] ref_add, ref_sub, ref_b;
    logic             ref_v;
    always_comb begin
        ref_add = a_q + b_q;
        ref_sub = a_q - b_q;
        ref_b   = (mode_q == OP_SUB) ? ~b_q : b_q;
        ref_v   = (a_q[WIDTH-1] == ref_b[WIDTH-1]) &&
                  (((mode_q == OP_SUB) ? ref_sub[WIDTH-1] : ref_add[WIDTH-1]) != a_q[WIDTH-1]);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (sum_q == '0 && !ovf_q));

    // R2
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OP_ADD) |=> (sum_q == $past(ref_add)));

    // R3
    sub_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OP_SUB) |=> (sum_q == $past(ref_sub)));

    // R4
    add_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OP_ADD) |=> (ovf_q == $past(ref_v)));

    // R5
    sub_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OP_SUB) |=> (ovf_q == $past(ref_v)));

    // R7
    mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mode_q == op_mode_e'($past(sub_mode))));

endmodule

// File: tb/test_registered_addsub.sv
module test_registered_addsub;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         sub_mode = 1'b0;
    logic [W-1:0] sum_q;
    logic         ovf_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    registered_addsub #(.WIDTH(W)) i_registered_addsub (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_in     (a_in),
        .b_in     (b_in),
        .sub_mode (sub_mode),
        .sum_q    (sum_q),
        .ovf_q    (ovf_q)
    );

    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic s);
        int ia, ib, r;
        ia = $signed(a);
        ib = $signed(b);
        r  = s ? ia - ib : ia + ib;
        model = {(r > 127 || r < -128), r[W-1:0]};
    endfunction

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got ovf=%0b sum=%02h, expected ovf=%0b sum=%02h",
                     req, act[W], act[W-1:0], exp[W], exp[W-1:0]);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        a_in = a; b_in = b; sub_mode = s;
    endtask

    // one isolated operation, checked two edges later
    task automatic single(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic s);
        apply(a, b, s);
        @(negedge clk);
        @(negedge clk);
        check(req, {ovf_q, sum_q}, model(a, b, s));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [W:0] e1, e2;
        logic       v1, v2;
        logic [W:0] prev;

        #1 rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 during reset", {ovf_q, sum_q}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {ovf_q, sum_q}, '0);

        // corner cases
        single("R5 -128-1", 8'h80, 8'h01, 1'b1);
        single("R4 127+1", 8'h7F, 8'h01, 1'b0);
        single("R4 -128+-128", 8'h80, 8'h80, 1'b0);
        single("R5 -128-(-128)", 8'h80, 8'h80, 1'b1);
        single("R3 0-(-128)", 8'h00, 8'h80, 1'b1);
        single("R2 -1+1", 8'hFF, 8'h01, 1'b0);

        // R6 latency: after one edge the old result stays
        prev = {ovf_q, sum_q};
        apply(8'h12, 8'h34, 1'b0);
        @(negedge clk);
        check("R6 one edge", {ovf_q, sum_q}, prev);
        @(negedge clk);
        check("R6 two edges", {ovf_q, sum_q}, model(8'h12, 8'h34, 1'b0));

        // R7 exhaustive stream, mode flipping every cycle, two passes
        for (int pass = 0; pass < 2; pass++) begin
            v1 = 1'b0; v2 = 1'b0; e1 = '0; e2 = '0;
            for (int i = 0; i < 65536 + 2; i++) begin
                if (v2) begin
                    if (e2[W]) check("R7 R4 R5 stream ovf", {ovf_q, sum_q}, e2);
                    else       check("R7 R2 R3 stream", {ovf_q, sum_q}, e2);
                end
                e2 = e1; v2 = v1;
                if (i < 65536) begin
                    logic s;
                    s = logic'((i ^ pass) & 1);
                    apply(W'(i >> 8), W'(i), s);
                    e1 = model(W'(i >> 8), W'(i), s);
                    v1 = 1'b1;
                end else begin
                    v1 = 1'b0;
                end
                @(negedge clk);
            end
        end

        // R8 asynchronous clear between edges
        single("R2 before reset", 8'h40, 8'h41, 1'b0);
        #1 rst_n = 1'b0;
        #0.5;
        check("R8 immediate clear", {ovf_q, sum_q}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R8 post clear", {ovf_q, sum_q}, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule